// File: doc/BRIEF.md
# Banked Fault Status Slice

This block keeps the bus-fault part of a processor's fault status state for a core that runs in a secure and a non-secure state. It holds two 32-bit copies of the combined fault status word, one per state, and one fault address register. Bus accesses from a memory-mapped port carry a secure attribute. That attribute picks which copy of the status word a read or write sees. The bus-fault byte (bits 15:8) is stored only once, in the non-secure copy, and both states share it.

A live routing input, `bf_to_nonsec`, decides whether the non-secure state may see bus faults. While it is 0, a non-secure requester reads the shared bus-fault byte and the address register as zero, and its writes to them have no effect. Status bits are cleared by writing ones. The address register is plain read/write. The core reports faults through two strobes: one ORs bits into a status copy, the other loads a new fault address.

Accesses may be a byte, a halfword or a word wide. Reads return data one cycle later through a two-state response sequencer. In `ST_IDLE` no response is pending. A read request moves it to `ST_RESP`. In `ST_RESP` it stays if another read arrives in that cycle, and otherwise returns to `ST_IDLE`. `rsp_valid` is high exactly while the sequencer is in `ST_RESP`.

Top module: `fsr_bank_top`

## Requirements
- R1: After reset, every stored bit is zero, `rsp_valid` is low, and any legal read returns zero.
- R2: Status bits outside 15:8 are banked. A secure access reaches only the secure copy, and a non-secure access reaches only the non-secure copy.
- R3: Status bits 15:8 exist once and are shared. A secure read always shows them. A non-secure read shows them when `bf_to_nonsec` is 1. A set or clear from either state acts on that single byte.
- R4: While `bf_to_nonsec` is 0, a non-secure read returns bits 15:8 of the status word as zero, and a non-secure write leaves those bits unchanged.
- R5: The fault address register is at byte offsets 4..7. It is read and written with byte-lane merging. While `bf_to_nonsec` is 0, a non-secure read returns zero and a non-secure write leaves the register unchanged.
- R6: A write to the status word (byte offsets 0..3) clears each stored bit that has a 1 in the placed write value. Bits with a 0 are left unchanged.
- R7: `acc_size` 0, 1 and 2 select 1, 2 and 4 bytes. The byte offset within the word is `acc_offset[1:0]`. Write data is taken right-justified and shifted left by 8 times that offset. Read data is returned right-justified, with the unused upper bytes zero.
- R8: A `flt_set_valid` pulse ORs `flt_set_bits` into the copy selected by `flt_set_secure`, except bits 15:8, which always go to the shared byte. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: The following accesses read zero and change nothing: `acc_size` 3, an offset not aligned to the access size, and word indices other than 0 and 1 (offsets 8..15).
- R10: A read request is answered with `rsp_valid` high on the next cycle, carrying the data. A write produces no response.
- R11: A `flt_addr_valid` pulse loads `flt_addr` into the fault address register. It takes precedence over a bus write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Bus access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | Secure attribute of the access |
| acc_offset | input | 4 | Byte offset in the slice window |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| acc_wdata | input | 32 | Right-justified write data |
| bf_to_nonsec | input | 1 | Bus faults visible to the non-secure state |
| flt_set_valid | input | 1 | Fault status set strobe from the core |
| flt_set_secure | input | 1 | Status copy targeted by the set strobe |
| flt_set_bits | input | 32 | Bits to set |
| flt_addr_valid | input | 1 | Fault address capture strobe |
| flt_addr | input | 32 | Captured fault address |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Right-justified read data |

## Verification
A wrong bit in either status copy stays hidden until a read through the matching view. It shows at the ports one cycle after that read, so the bench reads each copy after every change, both with routing on and with routing off. A leak of the shared byte or of the address register into the non-secure view shows on the first non-secure read taken while routing is off. A write that should have been blocked is only exposed by a later secure read, and the bench makes that read straight after the blocked write.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ADDR   = 2'd2
    } rd_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/fsr_decode.sv
module fsr_decode
    import fsr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int OFFSET_W   = 4,
    parameter int STATUS_IDX = 0,
    parameter int ADDR_IDX   = 1,
    localparam int LANES     = DATA_W / 8,
    localparam int LANE_W    = $clog2(LANES)
) (
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [OFFSET_W-1:0] acc_offset,
    input  logic [1:0]          acc_size,
    input  logic [DATA_W-1:0]   acc_wdata,
    output logic                rd_go,
    output rd_sel_e             rd_sel,
    output logic                wr_status,
    output logic                wr_addr,
    output logic [LANE_W-1:0]   lane,
    output logic [LANES-1:0]    byte_en,
    output logic [LANES-1:0]    keep_mask,
    output logic [DATA_W-1:0]   wval
);

    localparam int IDX_W = OFFSET_W - LANE_W;

    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] shifted;
    logic              legal;
    logic              hit_s;
    logic              hit_a;
    int                nbytes;

    assign word_idx = acc_offset[OFFSET_W-1:LANE_W];
    assign lane     = acc_offset[LANE_W-1:0];

    always_comb begin
        nbytes = 1 << int'(acc_size);
        legal  = (int'(acc_size) <= LANE_W) && ((int'(lane) % nbytes) == 0);
        for (int i = 0; i < LANES; i++) begin
            byte_en[i]   = legal && acc_valid && (i >= int'(lane)) && (i < int'(lane) + nbytes);
            keep_mask[i] = legal && (i < nbytes);
        end
        shifted = acc_wdata << (8 * int'(lane));
        for (int i = 0; i < LANES; i++) begin
            wval[8*i +: 8] = byte_en[i] ? shifted[8*i +: 8] : 8'h00;
        end
        hit_s     = legal && (word_idx == IDX_W'(STATUS_IDX));
        hit_a     = legal && (word_idx == IDX_W'(ADDR_IDX));
        rd_go     = acc_valid && !acc_write;
        wr_status = acc_valid && acc_write && hit_s;
        wr_addr   = acc_valid && acc_write && hit_a;
        if (hit_s)      rd_sel = SEL_STATUS;
        else if (hit_a) rd_sel = SEL_ADDR;
        else            rd_sel = SEL_NONE;
    end

endmodule

// File: rtl/fsr_status_bank.sv
module fsr_status_bank #(
    parameter int DATA_W  = 32,
    parameter int BF_LANE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              route_ns,
    input  logic              clr_en,
    input  logic              clr_sec,
    input  logic [DATA_W-1:0] clr_val,
    input  logic              set_en,
    input  logic              set_sec,
    input  logic [DATA_W-1:0] set_val,
    output logic [DATA_W-1:0] sec_view,
    output logic [DATA_W-1:0] ns_view
);

    localparam logic [DATA_W-1:0] BF_MASK = DATA_W'(8'hFF) << (8 * BF_LANE);

    logic [DATA_W-1:0] ns_q, ns_d, sec_q, sec_d;
    logic [DATA_W-1:0] ns_clr, sec_clr, ns_set, sec_set;

    always_comb begin
        ns_clr  = '0;
        sec_clr = '0;
        if (clr_en) begin
            if (clr_sec) begin
                sec_clr = clr_val & ~BF_MASK;
                ns_clr  = clr_val & BF_MASK;
            end else begin
                ns_clr = route_ns ? clr_val : (clr_val & ~BF_MASK);
            end
        end
        ns_set  = '0;
        sec_set = '0;
        if (set_en) begin
            ns_set = set_val & BF_MASK;
            if (set_sec) sec_set = set_val & ~BF_MASK;
            else         ns_set  = ns_set | (set_val & ~BF_MASK);
        end
        ns_d  = (ns_q & ~ns_clr) | ns_set;
        sec_d = ((sec_q & ~sec_clr) | sec_set) & ~BF_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns_q  <= '0;
            sec_q <= '0;
        end else begin
            ns_q  <= ns_d;
            sec_q <= sec_d;
        end
    end

    assign sec_view = (sec_q & ~BF_MASK) | (ns_q & BF_MASK);
    assign ns_view  = route_ns ? ns_q : (ns_q & ~BF_MASK);

    AST_BF_NS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && !clr_sec && !route_ns && !set_en |=> (ns_q & BF_MASK) == $past(ns_q & BF_MASK)); // R4
    AST_SEC_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && clr_sec && !set_en |=> (sec_q & $past(clr_val & ~BF_MASK)) == '0); // R6
    AST_BANK_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && clr_sec && !set_en |=> (ns_q & ~BF_MASK) == $past(ns_q & ~BF_MASK)); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (ns_q & $past(set_val & BF_MASK)) == $past(set_val & BF_MASK)); // R8

endmodule

// File: rtl/fsr_addr_reg.sv
module fsr_addr_reg #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allow,
    input  logic              wr_en,
    input  logic [LANES-1:0]  byte_en,
    input  logic [DATA_W-1:0] wval,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_val,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] d;
    logic              wr_ok;

    assign wr_ok = wr_en && allow;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign d[8*g +: 8] = cap_en ? cap_val[8*g +: 8] :
                             (wr_ok && byte_en[g]) ? wval[8*g +: 8] : q[8*g +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_FAR_NS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !allow && !cap_en |=> $stable(q)); // R5
    AST_FAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> q == $past(cap_val)); // R11

endmodule

// File: rtl/fsr_bank_top.sv
module fsr_bank_top
    import fsr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int OFFSET_W   = 4,
    parameter int STATUS_IDX = 0,
    parameter int ADDR_IDX   = 1,
    parameter int BF_LANE    = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic                acc_secure,
    input  logic [OFFSET_W-1:0] acc_offset,
    input  logic [1:0]          acc_size,
    input  logic [DATA_W-1:0]   acc_wdata,
    input  logic                bf_to_nonsec,
    input  logic                flt_set_valid,
    input  logic                flt_set_secure,
    input  logic [DATA_W-1:0]   flt_set_bits,
    input  logic                flt_addr_valid,
    input  logic [DATA_W-1:0]   flt_addr,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data
);

    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    logic              rd_go, wr_status, wr_addr;
    rd_sel_e           rd_sel;
    logic [LANE_W-1:0] lane;
    logic [LANES-1:0]  byte_en, keep_mask;
    logic [DATA_W-1:0] wval;
    logic [DATA_W-1:0] sec_view, ns_view, far_q;
    logic [DATA_W-1:0] rd_word, rd_shift, rd_bytes;
    logic              far_allow;
    rsp_state_e        state, state_nxt;

    fsr_decode #(
        .DATA_W(DATA_W), .OFFSET_W(OFFSET_W),
        .STATUS_IDX(STATUS_IDX), .ADDR_IDX(ADDR_IDX)
    ) u_decode (
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_offset(acc_offset),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .rd_go(rd_go), .rd_sel(rd_sel),
        .wr_status(wr_status), .wr_addr(wr_addr), .lane(lane), .byte_en(byte_en),
        .keep_mask(keep_mask), .wval(wval)
    );

    fsr_status_bank #(.DATA_W(DATA_W), .BF_LANE(BF_LANE)) u_status (
        .clk(clk), .rst_n(rst_n), .route_ns(bf_to_nonsec),
        .clr_en(wr_status), .clr_sec(acc_secure), .clr_val(wval),
        .set_en(flt_set_valid), .set_sec(flt_set_secure), .set_val(flt_set_bits),
        .sec_view(sec_view), .ns_view(ns_view)
    );

    assign far_allow = acc_secure || bf_to_nonsec;

    fsr_addr_reg #(.DATA_W(DATA_W)) u_far (
        .clk(clk), .rst_n(rst_n), .allow(far_allow), .wr_en(wr_addr),
        .byte_en(byte_en), .wval(wval), .cap_en(flt_addr_valid),
        .cap_val(flt_addr), .q(far_q)
    );

    always_comb begin
        unique case (rd_sel)
            SEL_STATUS: rd_word = acc_secure ? sec_view : ns_view;
            SEL_ADDR:   rd_word = far_allow ? far_q : '0;
            default:    rd_word = '0;
        endcase
        rd_shift = rd_word >> (8 * int'(lane));
        for (int i = 0; i < LANES; i++) begin
            rd_bytes[8*i +: 8] = keep_mask[i] ? rd_shift[8*i +: 8] : 8'h00;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = rd_go ? ST_RESP : ST_IDLE;
            ST_RESP: state_nxt = rd_go ? ST_RESP : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rsp_data <= '0;
        else if (rd_go) rsp_data <= rd_bytes;
    end

    assign rsp_valid = (state == ST_RESP);

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> rsp_valid); // R10
    AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write |=> !rsp_valid); // R10
    AST_NS_FAR_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go && rd_sel == SEL_ADDR && !acc_secure && !bf_to_nonsec |=> rsp_data == '0); // R5

endmodule

// File: tb/test_fsr_bank_top.sv
module test_fsr_bank_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write, acc_secure;
    logic [3:0]  acc_offset;
    logic [1:0]  acc_size;
    logic [31:0] acc_wdata;
    logic        bf_to_nonsec;
    logic        flt_set_valid, flt_set_secure;
    logic [31:0] flt_set_bits;
    logic        flt_addr_valid;
    logic [31:0] flt_addr;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    fsr_bank_top i_fsr_bank_top (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_secure(acc_secure), .acc_offset(acc_offset), .acc_size(acc_size),
        .acc_wdata(acc_wdata), .bf_to_nonsec(bf_to_nonsec),
        .flt_set_valid(flt_set_valid), .flt_set_secure(flt_set_secure),
        .flt_set_bits(flt_set_bits), .flt_addr_valid(flt_addr_valid),
        .flt_addr(flt_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected item for each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected response", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, rsp_data, e.data);
            end
        end
    end

    task automatic access(input bit wr, input bit sec, input logic [3:0] off, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] exp, input string tag);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_secure = sec;
        acc_offset = off;
        acc_size   = sz;
        acc_wdata  = wd;
        if (!wr) exp_q.push_back('{data: exp, tag: tag});
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic rd(input bit sec, input logic [3:0] off, input logic [1:0] sz,
                      input logic [31:0] exp, input string tag);
        access(1'b0, sec, off, sz, 32'h0, exp, tag);
    endtask

    task automatic wr(input bit sec, input logic [3:0] off, input logic [1:0] sz,
                      input logic [31:0] wd);
        access(1'b1, sec, off, sz, wd, 32'h0, "");
        check("R10 no response after write", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic pulse_set(input bit sec, input logic [31:0] bits);
        flt_set_valid  = 1'b1;
        flt_set_secure = sec;
        flt_set_bits   = bits;
        @(negedge clk);
        flt_set_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        check("R10 all reads answered", exp_q.size(), 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        acc_valid = 0; acc_write = 0; acc_secure = 0; acc_offset = 0; acc_size = 0;
        acc_wdata = 0; bf_to_nonsec = 0; flt_set_valid = 0; flt_set_secure = 0;
        flt_set_bits = 0; flt_addr_valid = 0; flt_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        rd(1, 4'd0, 2'd2, 32'h0, "R1 secure status after reset");
        rd(0, 4'd4, 2'd2, 32'h0, "R1 address after reset");
        rd(1, 4'd4, 2'd2, 32'h0, "R1 secure address after reset");

        // R8/R3 set strobes: ns=00A05503 then BF |= 22 -> 00A07703, sec=0C000060
        pulse_set(0, 32'h00A0_5503);
        pulse_set(1, 32'h0C00_2260);
        bf_to_nonsec = 0;
        rd(0, 4'd0, 2'd2, 32'h00A0_0003, "R4 ns word with BF hidden");
        rd(1, 4'd0, 2'd2, 32'h0C00_7760, "R2 R3 secure word view");
        rd(0, 4'd1, 2'd0, 32'h0, "R4 ns BF byte reads zero");
        rd(1, 4'd1, 2'd0, 32'h77, "R7 secure byte at offset 1");
        rd(1, 4'd2, 2'd1, 32'h0C00, "R7 secure half at offset 2");
        rd(0, 4'd2, 2'd0, 32'hA0, "R7 ns byte at offset 2");
        bf_to_nonsec = 1;
        rd(0, 4'd0, 2'd2, 32'h00A0_7703, "R3 ns word with BF visible");
        rd(0, 4'd1, 2'd0, 32'h77, "R3 ns BF byte visible");

        // R4/R6: ns clear with routing off leaves BF, clears bit0
        bf_to_nonsec = 0;
        wr(0, 4'd0, 2'd2, 32'h0000_FF01);
        rd(1, 4'd1, 2'd0, 32'h77, "R4 ns write ignored on BF byte");
        rd(0, 4'd0, 2'd2, 32'h00A0_0002, "R6 ns W1C of bit0");

        // R6/R3/R7: secure clears on shared byte and upper half
        wr(1, 4'd1, 2'd0, 32'h05);
        wr(1, 4'd2, 2'd1, 32'h0400);
        rd(1, 4'd0, 2'd2, 32'h0800_7260, "R6 R3 secure W1C on shared and banked");
        rd(0, 4'd0, 2'd2, 32'h00A0_0002, "R2 ns copy untouched by secure clear");

        // R9 illegal accesses
        wr(1, 4'd1, 2'd1, 32'h0000_FFFF);
        rd(1, 4'd0, 2'd2, 32'h0800_7260, "R9 misaligned write ignored");
        rd(1, 4'd1, 2'd1, 32'h0, "R9 misaligned read zero");
        rd(1, 4'd0, 2'd3, 32'h0, "R9 reserved size read zero");
        rd(1, 4'd8, 2'd2, 32'h0, "R9 unmapped word read zero");

        // R8 set wins over same-cycle clear
        flt_set_valid = 1; flt_set_secure = 1; flt_set_bits = 32'h0000_0020;
        access(1'b1, 1'b1, 4'd0, 2'd2, 32'h0000_0060, 32'h0, "");
        flt_set_valid = 0;
        rd(1, 4'd0, 2'd0, 32'h20, "R8 set wins over clear");
        rd(1, 4'd0, 2'd2, 32'h0800_7220, "R8 other bits unchanged");

        // R5 address register
        wr(1, 4'd4, 2'd2, 32'h2000_1234);
        rd(1, 4'd4, 2'd2, 32'h2000_1234, "R5 secure address read");
        rd(0, 4'd4, 2'd2, 32'h0, "R5 ns address hidden");
        wr(0, 4'd4, 2'd2, 32'hFFFF_FFFF);
        rd(1, 4'd4, 2'd2, 32'h2000_1234, "R5 ns address write ignored");
        bf_to_nonsec = 1;
        rd(0, 4'd4, 2'd2, 32'h2000_1234, "R5 ns address visible");
        wr(0, 4'd5, 2'd0, 32'hAB);
        rd(0, 4'd6, 2'd1, 32'h2000, "R7 ns half of address");
        rd(1, 4'd4, 2'd2, 32'h2000_AB34, "R5 R7 byte lane merge");

        // R11 capture wins over bus write
        flt_addr_valid = 1; flt_addr = 32'hDEAD_0000;
        access(1'b1, 1'b1, 4'd4, 2'd2, 32'h1111_1111, 32'h0, "");
        flt_addr_valid = 0;
        rd(1, 4'd4, 2'd2, 32'hDEAD_0000, "R11 capture wins");

        drain();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule